// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a 256-byte electrically erasable memory that answers as a target on a two-wire I2C bus. A fast system clock samples the clock and data lines through a short synchronizer. Edge detection on the sampled lines finds start and stop conditions, clock edges and data bits. The block decodes a 7-bit device address whose upper four bits are a fixed family code and whose lower three bits come from strap inputs, so eight such devices can share one bus. The data line is open-drain: the block never drives it high. It only asserts an enable that pulls the line low.

After a write-direction device address, the master sends a word address and then one or more data bytes. Each data byte is stored at once and the page offset advances. For reads, the block sends bytes from a persistent address counter, which always holds the last accessed location plus one. A master acknowledge asks for the next byte. A master non-acknowledge followed by a stop ends the transfer. A random read is a dummy write of the word address, then a repeated start in the read direction. A write-protect input, when high, blocks array updates without changing the bus handshake. The nonvolatile programming delay and the analog bus timing are not modelled.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset the data-line pull-down enable is low, every array byte reads 0x00 and the address counter is 0, so a first current-address read returns the byte at address 0.
- R2: The device address byte is sent MSB first as 1010, then strap[2], strap[1], strap[0], then a direction bit (1 = read). A matching byte is acknowledged by holding SDA low through the ninth SCL pulse. A non-matching byte is not acknowledged, and the device ignores the bus until the next start.
- R3: A byte write (device address with direction 0, word address, one data byte, stop) stores the byte at the word address. The word address and the data byte are each acknowledged.
- R4: In a write, each stored byte advances only the low 3 bits of the address counter. Successive data bytes therefore fill one 8-byte page, and a ninth byte wraps to the start of that page and overwrites it.
- R5: A current-address read returns the byte at the address counter. The counter holds the last accessed address plus one. After a write, the plus-one wraps within the page.
- R6: A random read (write-direction device address, word address, repeated start, read-direction device address) returns the byte at that word address.
- R7: During a read, each master acknowledge makes the device send the byte at the next address. The read address runs over the full 8-bit range and wraps from 0xFF to 0x00.
- R8: A master non-acknowledge followed by a stop releases SDA and returns the device to idle. The address counter is kept for the next current-address read.
- R9: While the write-protect input is high, written bytes are still acknowledged but the array is left unchanged.
- R10: Bits are captured on the SCL rising edge. The device changes its SDA drive only while SCL is low, and its output stays steady while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the wire |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| sdaOe | output | 1 | Pull-down enable for the data line (1 drives low) |
| strap | input | 3 | Strapped low bits of the device address |
| wpIn | input | 1 | Write protect, high blocks array updates |

## Verification
The bench builds the block with its default parameters: an 8-bit word address (256 bytes), a 3-bit page offset and a two-stage synchronizer. The straps are tied to 101. With a 256-byte array, a short sequential read crosses the 0xFF to 0x00 boundary. With an 8-byte page, a ten-byte page write is enough to show the wrap inside the page. Each quarter of a bus bit lasts several system clocks, so the synchronizer delay stays inside the SCL low time. The steadiness of SDA while SCL is high is sampled twice on every bit the device drives.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  // strobes from the protocol control to the storage datapath
  typedef struct packed {
    logic shiftIn;    // capture one received bit
    logic loadAddr;   // received byte becomes the word address
    logic writeByte;  // store received byte, advance page offset
    logic loadTx;     // fetch byte for transmit, advance address
    logic shiftTx;    // present next transmit bit
  } strb_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEVACK,
    ST_WADDR,
    ST_WADDRACK,
    ST_WDATA,
    ST_WDATAACK,
    ST_TX,
    ST_MACK
  } ctlState_e;

endpackage

// File: rtl/eeprom_i2c_sync.sv
module eeprom_i2c_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  // bus lines idle high, so the chain resets to ones
  if (STAGES <= 1) begin : g_single
    always_ff @(posedge clk) begin
      if (!rstN) dout <= '1;
      else       dout <= din;
    end
  end else begin : g_chain
    logic [STAGES-1:0][W-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], din};
    end
    assign dout = chain[STAGES-1];
  end

endmodule

// File: rtl/eeprom_i2c_dp.sv
module eeprom_i2c_dp
  import eeprom_i2c_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic              sdaBit,
  input  logic              wpIn,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] addrCnt
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
  localparam logic [PAGE_W-1:0] PAGE_ONE = 1;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      addrCnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaBit};
      if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (strb.loadAddr) begin
        addrCnt <= rxShift[ADDR_W-1:0];
      end else if (strb.writeByte) begin
        if (!wpIn) mem[addrCnt] <= rxShift;
        addrCnt <= {addrCnt[ADDR_W-1:PAGE_W], addrCnt[PAGE_W-1:0] + PAGE_ONE};
      end else if (strb.loadTx) begin
        txShift <= mem[addrCnt];
        addrCnt <= addrCnt + ADDR_ONE;
      end
    end
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[BYTE_W-1];

endmodule

// File: rtl/eeprom_i2c_ctrl.sv
module eeprom_i2c_ctrl
  import eeprom_i2c_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic [2:0]        strap,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  output strb_t             strb,
  output logic              sdaOe
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = 1;

  ctlState_e st, stNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic ackDrive, ackNext;
  logic isRead, readNext;
  logic masterAck, mAckNext;
  logic sclPrev, sdaPrev;
  logic sclRise, sclFall, startEv, stopEv, byteDone, inAck;

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startEv  = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv   = sclS & sclPrev & ~sdaPrev & sdaS;
  assign byteDone = sclFall && (bitCnt == FULL_CNT);

  always_comb begin
    stNext   = st;
    cntNext  = bitCnt;
    ackNext  = ackDrive;
    readNext = isRead;
    mAckNext = masterAck;
    strb     = '0;
    if (startEv) begin
      stNext  = ST_DEV;
      cntNext = '0;
      ackNext = 1'b0;
    end else if (stopEv) begin
      stNext  = ST_IDLE;
      ackNext = 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (sclRise && bitCnt < FULL_CNT) begin
            strb.shiftIn = 1'b1;
            cntNext      = bitCnt + CNT_ONE;
          end else if (byteDone) begin
            cntNext = '0;
            if (st == ST_DEV) begin
              if (rxByte[BYTE_W-1:1] == {DEV_ID, strap}) begin
                ackNext  = 1'b1;
                readNext = rxByte[0];
                stNext   = ST_DEVACK;
              end else begin
                stNext = ST_IDLE;
              end
            end else if (st == ST_WADDR) begin
              strb.loadAddr = 1'b1;
              ackNext       = 1'b1;
              stNext        = ST_WADDRACK;
            end else begin
              strb.writeByte = 1'b1;
              ackNext        = 1'b1;
              stNext         = ST_WDATAACK;
            end
          end
        end
        ST_DEVACK, ST_WADDRACK, ST_WDATAACK: begin
          if (sclFall) begin
            ackNext = 1'b0;
            cntNext = '0;
            if (st == ST_DEVACK) begin
              if (isRead) begin
                strb.loadTx = 1'b1;
                stNext      = ST_TX;
              end else begin
                stNext = ST_WADDR;
              end
            end else begin
              stNext = ST_WDATA;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              stNext  = ST_MACK;
              cntNext = '0;
            end else begin
              strb.shiftTx = 1'b1;
              cntNext      = bitCnt + CNT_ONE;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            mAckNext = ~sdaS;
          end else if (sclFall) begin
            if (masterAck) begin
              strb.loadTx = 1'b1;
              stNext      = ST_TX;
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
    end else begin
      st        <= stNext;
      bitCnt    <= cntNext;
      ackDrive  <= ackNext;
      isRead    <= readNext;
      masterAck <= mAckNext;
      sclPrev   <= sclS;
      sdaPrev   <= sdaS;
    end
  end

  assign inAck = (st == ST_DEVACK) || (st == ST_WADDRACK) || (st == ST_WDATAACK);
  assign sdaOe = (inAck && ackDrive) || ((st == ST_TX) && !txBit);

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eeprom_i2c_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic [2:0] strap,
  input  logic       wpIn
);

  logic sclS, sdaS, txBit;
  logic [BYTE_W-1:0] rxByte;
  logic [ADDR_W-1:0] addrCnt;
  strb_t strb;

  eeprom_i2c_sync #(.STAGES(SYNC_STAGES), .W(2)) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din ({sclIn, sdaIn}),
    .dout({sclS, sdaS})
  );

  eeprom_i2c_ctrl #(.DEV_ID(DEV_ID)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .sclS  (sclS),
    .sdaS  (sdaS),
    .strap (strap),
    .rxByte(rxByte),
    .txBit (txBit),
    .strb  (strb),
    .sdaOe (sdaOe)
  );

  eeprom_i2c_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .sdaBit (sdaS),
    .wpIn   (wpIn),
    .rxByte (rxByte),
    .txBit  (txBit),
    .addrCnt(addrCnt)
  );

endmodule

// File: rtl/eeprom_i2c_chk.sv
module eeprom_i2c_chk
  import eeprom_i2c_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input strb_t             strb,
  input logic [ADDR_W-1:0] addrCnt
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
  localparam logic [PAGE_W-1:0] PAGE_ONE = 1;

  logic firstCyc;
  always_ff @(posedge clk) begin
    if (!rstN) firstCyc <= 1'b1;
    else       firstCyc <= 1'b0;
  end

  // R1
  always_ff @(posedge clk) begin
    if (rstN && firstCyc === 1'b1)
      rst_release_chk: assert (!sdaOe);
  end

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R3
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R4
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeByte |=> (addrCnt[ADDR_W-1:PAGE_W] == $past(addrCnt[ADDR_W-1:PAGE_W]))
                    && (addrCnt[PAGE_W-1:0] == $past(addrCnt[PAGE_W-1:0]) + PAGE_ONE));

  // R7
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |=> addrCnt == $past(addrCnt) + ADDR_ONE);

endmodule

bind eeprom_i2c_target eeprom_i2c_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .sclIn  (sclIn),
  .sdaOe  (sdaOe),
  .strb   (strb),
  .addrCnt(addrCnt)
);

// File: tb/eeprom_i2c_target_tb_top.sv
module eeprom_i2c_target_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sdaOe;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaOe;

  eeprom_i2c_target dut_i (
    .clk  (clk),
    .rstN (rstN),
    .sclIn(sclM),
    .sdaIn(sdaLine),
    .sdaOe(sdaOe),
    .strap(strap),
    .wpIn (wp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] refMem [256];
  logic [7:0] refAddr = 8'h00;
  logic [7:0] wbuf [16];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(posedge clk);
    #1;
  endtask

  // bus primitives, data set while SCL is low
  task automatic busStart();
    sclM = 1'b0; waitQ();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBit(input bit b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
  endtask

  // R10: sampled twice while SCL is high
  task automatic recvBit(output bit b);
    bit late;
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    b = sdaLine; waitQ();
    late = sdaLine;
    sclM = 1'b0; waitQ();
    chk("R10 SDA steady while SCL high", late, b);
  endtask

  task automatic sendByte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = !b;
  endtask

  task automatic recvByte(output logic [7:0] d, input bit giveAck);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(!giveAck);
  endtask

  function automatic void modelWrite(input logic [7:0] d);
    if (!wp) refMem[refAddr] = d;
    refAddr = {refAddr[7:3], refAddr[2:0] + 3'd1};
  endfunction

  function automatic logic [7:0] modelRead();
    logic [7:0] r;
    r = refMem[refAddr];
    refAddr = refAddr + 8'd1;
    return r;
  endfunction

  task automatic devAddr(input bit rd, input string tag);
    bit a;
    busStart();
    sendByte({4'b1010, strap, rd}, a);
    chk({tag, " R2 device address ack"}, a, 1);
  endtask

  task automatic writeSeq(input logic [7:0] wa, input int n, input string tag);
    bit a;
    devAddr(1'b0, tag);
    sendByte(wa, a);
    chk({tag, " R3 word address ack"}, a, 1);
    refAddr = wa;
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], a);
      chk({tag, " data ack"}, a, 1);
      modelWrite(wbuf[i]);
    end
    busStop();
  endtask

  task automatic readSeq(input int n, input bit rnd, input logic [7:0] wa, input string tag);
    bit a;
    logic [7:0] d;
    logic [7:0] e;
    if (rnd) begin
      devAddr(1'b0, tag);
      sendByte(wa, a);
      chk({tag, " R6 word address ack"}, a, 1);
      refAddr = wa;
    end
    devAddr(1'b1, tag);
    for (int i = 0; i < n; i++) begin
      recvByte(d, i < n - 1);
      e = modelRead();
      chk({tag, " data"}, d, e);
    end
    busStop();
    chk({tag, " R8 SDA released after stop"}, sdaOe, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    int unsigned seedVal;
    seedVal = $urandom(32'd4242);
    for (int i = 0; i < 256; i++) refMem[i] = 8'h00;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    waitQ();
    chk("R1 SDA released after reset", sdaOe, 0);
    readSeq(2, 1'b0, 8'h00, "R1 R5 current read after reset");

    // R2: foreign strap and foreign family code, then ignored bytes
    busStart();
    sendByte({4'b1010, 3'b100, 1'b0}, a);
    chk("R2 foreign strap not acked", a, 0);
    sendByte(8'h10, a);
    chk("R2 ignored word address", a, 0);
    sendByte(8'h77, a);
    chk("R2 ignored data", a, 0);
    busStop();
    busStart();
    sendByte({4'b1110, strap, 1'b0}, a);
    chk("R2 foreign family not acked", a, 0);
    busStop();
    readSeq(1, 1'b1, 8'h10, "R2 array untouched");

    // R3 / R6 / R5
    wbuf[0] = 8'h5A;
    writeSeq(8'h10, 1, "R3 byte write");
    readSeq(1, 1'b1, 8'h10, "R6 random read");
    readSeq(1, 1'b0, 8'h00, "R5 current read after random read");

    // R4 full page and wrapped page
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hC0 + 8'(i);
    writeSeq(8'h20, 8, "R4 full page");
    readSeq(8, 1'b1, 8'h20, "R4 page readback");
    for (int i = 0; i < 10; i++) wbuf[i] = 8'h30 + 8'(i);
    writeSeq(8'h45, 10, "R4 page wrap");
    readSeq(8, 1'b1, 8'h40, "R4 wrapped page readback");
    readSeq(1, 1'b0, 8'h00, "R5 current read after page write");
    wbuf[0] = 8'h11;
    writeSeq(8'h47, 1, "R5 write at page end");
    readSeq(1, 1'b0, 8'h00, "R5 counter wraps in page");

    // R7 read across the top of the array
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hE0 + 8'(i);
    writeSeq(8'hF8, 8, "R7 top page fill");
    wbuf[0] = 8'h9C;
    writeSeq(8'h00, 1, "R7 bottom fill");
    readSeq(4, 1'b1, 8'hFE, "R7 sequential wrap");
    readSeq(2, 1'b0, 8'h00, "R8 counter kept after NACK");

    // R9 write protect
    wp = 1'b1;
    wbuf[0] = 8'hA5;
    wbuf[1] = 8'h3C;
    writeSeq(8'h10, 2, "R9 protected write");
    wp = 1'b0;
    readSeq(2, 1'b1, 8'h10, "R9 protected readback");

    // constrained random mix
    for (int t = 0; t < 14; t++) begin
      int kind;
      int n;
      logic [7:0] wa;
      kind = int'($urandom_range(2, 0));
      wa = 8'($urandom());
      if (kind == 0) begin
        n = int'($urandom_range(10, 1));
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
        wp = ($urandom_range(4, 0) == 0);
        writeSeq(wa, n, wp ? "R9 random protected write" : "R4 random write");
        wp = 1'b0;
      end else if (kind == 1) begin
        n = int'($urandom_range(6, 1));
        readSeq(n, 1'b1, wa, "R7 random sequential read");
      end else begin
        n = int'($urandom_range(4, 1));
        readSeq(n, 1'b0, 8'h00, "R5 random current read");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule